// File: doc/BRIEF.md
# Blocking Two-Port Memory Request Forwarder

This block sits between two requester ports, an instruction port and a data port, and a single memory port. It accepts one request at a time, passes it to memory with its fields unchanged, and steers the memory's reply back to the requester. The reply goes to the instruction port when the request was an instruction fetch, and to the data port otherwise. Only one transaction may be in flight.

Each link uses an accept-or-refuse handshake followed by a retry. A sender drives a packet for one cycle. If the receiver refuses it, the packet waits in a one-entry holding slot until the receiver pulses a retry. The packet is then offered again, and it may be refused again. A request that the forwarder refuses is remembered as an owed retry. After a later memory reply, the forwarder pulses a one-cycle retry to that requester, provided the requester's reply slot is empty.

The forwarder always takes replies from memory. Arrival of a reply frees the forwarder in that same cycle, so a new request presented in that cycle is accepted.

Top module: `fwd_two_port`

## Requirements
- R1: During reset and in the first cycle after it, `mem_req_valid`, `cpu_rsp_valid` and `cpu_retry` are all 0. The forwarder accepts the first request that follows reset.
- R2: A request that is accepted (`cpu_req_accept` high in the cycle it is presented) appears on `mem_req_*` in the next cycle. It carries the same address, write flag, write data and fetch flag.
- R3: While a request is outstanding (accepted, and no reply yet), requests on either port are refused in the same cycle (`cpu_req_accept` = 0).
- R4: A reply (`mem_rsp_valid`) is offered one cycle later, with the same data. It goes to port 0 (instruction) when the accepted request had fetch = 1, and to port 1 (data) when fetch = 0. This routing does not depend on which port issued the request.
- R5: In the cycle `mem_rsp_valid` is high, a newly presented request is accepted.
- R6: If both ports present a request in the same free cycle, port 0 is accepted and port 1 is refused. Port 1 then owes a retry.
- R7: A port that was refused receives exactly one single-cycle `cpu_retry` pulse. The pulse comes in the cycle after the next reply that arrives while its reply slot is empty.
- R8: A port that owes a retry gets no pulse while its own reply slot holds a refused reply. The debt is kept and paid after a later reply.
- R9: If memory refuses a request (`mem_req_accept` = 0 while `mem_req_valid` = 1), `mem_req_valid` drops in the next cycle. The same request is offered again in the cycle after a `mem_req_retry` pulse. This can repeat.
- R10: If a requester refuses a reply, `cpu_rsp_valid` for that port drops in the next cycle. The same data is offered again in the cycle after a `cpu_rsp_retry` pulse for that port.
- R11: Loading a new packet into a holding slot that is still occupied is an error. It is never done on a legal stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 2 | Request presented, one bit per port (0 = instruction, 1 = data) |
| cpu_req_addr | input | 2 x ADDR_W | Request address per port |
| cpu_req_we | input | 2 | Write flag per port |
| cpu_req_wdata | input | 2 x DATA_W | Write data per port |
| cpu_req_fetch | input | 2 | Instruction-fetch flag per port |
| cpu_req_accept | output | 2 | Request taken this cycle; low with valid means refused |
| cpu_retry | output | 2 | One-cycle pulse inviting a refused port to try again |
| cpu_rsp_valid | output | 2 | Reply offered to each port |
| cpu_rsp_data | output | 2 x DATA_W | Reply data per port |
| cpu_rsp_accept | input | 2 | Requester takes the offered reply |
| cpu_rsp_retry | input | 2 | Requester invites a refused reply again |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_addr | output | ADDR_W | Forwarded address |
| mem_req_we | output | 1 | Forwarded write flag |
| mem_req_wdata | output | DATA_W | Forwarded write data |
| mem_req_fetch | output | 1 | Forwarded fetch flag |
| mem_req_accept | input | 1 | Memory takes the offered request |
| mem_req_retry | input | 1 | Memory invites a refused request again |
| mem_rsp_valid | input | 1 | Reply from memory, always taken |
| mem_rsp_data | input | DATA_W | Reply data from memory |

## Verification
The bench targets the cycle in which a reply arrives. At that edge a design could keep the busy flag set and refuse the new request, or pulse the retry to the wrong port. It also covers a fetch flag carried on the data port: a design that routed replies by the issuing port instead of by the flag would send that reply to the wrong requester. Refused packets are sent again after two refusals in a row, which would expose a slot that drops or corrupts its contents. An owed retry is set up while the owing port's reply slot is full, so a design that ignored the slot check would pulse too early, and one that cleared the debt would never pulse.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NPORTS    = 2;
  localparam int PORT_INST = 0;
  localparam int PORT_DATA = 1;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_SEND  = 2'd1,
    SLOT_HELD  = 2'd2
  } slot_state_e;
endpackage

// File: rtl/fwd_hold_slot.sv
// One-entry sender: offers a packet for a cycle, parks it on refusal,
// re-offers it after the peer's retry pulse.
module fwd_hold_slot
  import fwd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         peer_accept,
  input  logic         peer_retry,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         occupied
);
  slot_state_e st_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SLOT_EMPTY;
      data_q <= '0;
    end else begin
      case (st_q)
        SLOT_EMPTY: begin
          if (load) begin
            st_q   <= SLOT_SEND;
            data_q <= load_data;
          end
        end
        SLOT_SEND: begin
          if (peer_accept) st_q <= SLOT_EMPTY;
          else             st_q <= SLOT_HELD;
        end
        SLOT_HELD: begin
          if (peer_retry) st_q <= SLOT_SEND;
        end
        default: st_q <= SLOT_EMPTY;
      endcase
    end
  end

  assign out_valid = (st_q == SLOT_SEND);
  assign out_data  = data_q;
  assign occupied  = (st_q != SLOT_EMPTY);
endmodule

// File: rtl/fwd_admit.sv
// Admission control: busy flag, fixed-priority grant, owed-retry
// bookkeeping and the retry pulses.
module fwd_admit
  import fwd_pkg::*;
#(
  parameter int NP = NPORTS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NP-1:0]   req_valid,
  input  logic [NP-1:0]   req_fetch,
  input  logic            mem_rsp_valid,
  input  logic [NP-1:0]   slot_occ,
  output logic [NP-1:0]   req_accept,
  output logic [$clog2(NP)-1:0] grant_idx,
  output logic            any_grant,
  output logic [NP-1:0]   retry,
  output logic            fetch_q
);
  localparam int IDXW = $clog2(NP);

  logic          busy_q;
  logic          free;
  logic [NP-1:0] owed_q;
  logic [NP-1:0] retry_q;
  logic [NP-1:0] refused;
  logic [NP-1:0] issue;

  // A reply frees the forwarder in the cycle it arrives.
  assign free = !busy_q || mem_rsp_valid;

  always_comb begin
    req_accept = '0;
    grant_idx  = '0;
    any_grant  = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (req_valid[i] && free && !any_grant) begin
        req_accept[i] = 1'b1;
        grant_idx     = IDXW'(i);
        any_grant     = 1'b1;
      end
    end
    refused = req_valid & ~req_accept;
    issue   = {NP{mem_rsp_valid}} & owed_q & ~slot_occ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      fetch_q <= 1'b0;
      owed_q  <= '0;
      retry_q <= '0;
    end else begin
      if (any_grant) begin
        busy_q  <= 1'b1;
        fetch_q <= req_fetch[grant_idx];
      end else if (mem_rsp_valid) begin
        busy_q  <= 1'b0;
      end
      retry_q <= issue;
      owed_q  <= refused | (owed_q & ~issue);
    end
  end

  assign retry = retry_q;
endmodule

// File: rtl/fwd_two_port.sv
module fwd_two_port
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NPORTS-1:0]              cpu_req_valid,
  input  logic [NPORTS-1:0][ADDR_W-1:0]  cpu_req_addr,
  input  logic [NPORTS-1:0]              cpu_req_we,
  input  logic [NPORTS-1:0][DATA_W-1:0]  cpu_req_wdata,
  input  logic [NPORTS-1:0]              cpu_req_fetch,
  output logic [NPORTS-1:0]              cpu_req_accept,
  output logic [NPORTS-1:0]              cpu_retry,
  output logic [NPORTS-1:0]              cpu_rsp_valid,
  output logic [NPORTS-1:0][DATA_W-1:0]  cpu_rsp_data,
  input  logic [NPORTS-1:0]              cpu_rsp_accept,
  input  logic [NPORTS-1:0]              cpu_rsp_retry,
  output logic                           mem_req_valid,
  output logic [ADDR_W-1:0]              mem_req_addr,
  output logic                           mem_req_we,
  output logic [DATA_W-1:0]              mem_req_wdata,
  output logic                           mem_req_fetch,
  input  logic                           mem_req_accept,
  input  logic                           mem_req_retry,
  input  logic                           mem_rsp_valid,
  input  logic [DATA_W-1:0]              mem_rsp_data
);
  localparam int REQ_W = ADDR_W + DATA_W + 2;
  localparam int IDXW  = $clog2(NPORTS);

  logic [IDXW-1:0]   grant_idx;
  logic              any_grant;
  logic              fetch_q;
  logic [NPORTS-1:0] rsp_load;
  logic [NPORTS-1:0] rsp_occ;
  logic              mem_load;
  logic              mem_occ;
  logic [REQ_W-1:0]  req_pack;
  logic [REQ_W-1:0]  mem_pack;

  fwd_admit #(.NP(NPORTS)) u_admit (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (cpu_req_valid),
    .req_fetch     (cpu_req_fetch),
    .mem_rsp_valid (mem_rsp_valid),
    .slot_occ      (rsp_occ),
    .req_accept    (cpu_req_accept),
    .grant_idx     (grant_idx),
    .any_grant     (any_grant),
    .retry         (cpu_retry),
    .fetch_q       (fetch_q)
  );

  // Forward the granted port's fields unchanged.
  always_comb begin
    req_pack = {cpu_req_addr[grant_idx], cpu_req_we[grant_idx],
                cpu_req_wdata[grant_idx], cpu_req_fetch[grant_idx]};
  end
  assign mem_load = any_grant;

  fwd_hold_slot #(.W(REQ_W)) u_mem_slot (
    .clk         (clk),
    .rst         (rst),
    .load        (mem_load),
    .load_data   (req_pack),
    .peer_accept (mem_req_accept),
    .peer_retry  (mem_req_retry),
    .out_valid   (mem_req_valid),
    .out_data    (mem_pack),
    .occupied    (mem_occ)
  );

  assign {mem_req_addr, mem_req_we, mem_req_wdata, mem_req_fetch} = mem_pack;

  // Reply steering follows the captured fetch flag, not the issuing port.
  for (genvar g = 0; g < NPORTS; g++) begin : g_rsp
    localparam logic ROUTE_FETCH = (g == PORT_INST);
    assign rsp_load[g] = mem_rsp_valid && (fetch_q == ROUTE_FETCH);

    fwd_hold_slot #(.W(DATA_W)) u_rsp_slot (
      .clk         (clk),
      .rst         (rst),
      .load        (rsp_load[g]),
      .load_data   (mem_rsp_data),
      .peer_accept (cpu_rsp_accept[g]),
      .peer_retry  (cpu_rsp_retry[g]),
      .out_valid   (cpu_rsp_valid[g]),
      .out_data    (cpu_rsp_data[g]),
      .occupied    (rsp_occ[g])
    );
  end
endmodule

// File: rtl/fwd_two_port_chk.sv
module fwd_two_port_chk
  import fwd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NPORTS-1:0] cpu_req_valid,
  input logic [NPORTS-1:0] cpu_req_accept,
  input logic [NPORTS-1:0] cpu_retry,
  input logic [NPORTS-1:0] cpu_rsp_valid,
  input logic [NPORTS-1:0] cpu_rsp_accept,
  input logic              mem_req_valid,
  input logic              mem_req_accept,
  input logic              mem_rsp_valid,
  input logic              mem_load,
  input logic              mem_occ,
  input logic [NPORTS-1:0] rsp_load,
  input logic [NPORTS-1:0] rsp_occ
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req_valid && cpu_rsp_valid == '0 && cpu_retry == '0));

  assert_accept_forwarded_R2: assert property (@(posedge clk) disable iff (rst)
    $past(|cpu_req_accept) |-> mem_req_valid);

  assert_refuse_in_flight_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(|cpu_req_accept) && !mem_rsp_valid) |-> (cpu_req_accept == '0));

  assert_reply_offered_R4: assert property (@(posedge clk) disable iff (rst)
    $past(mem_rsp_valid) |-> (|cpu_rsp_valid));

  assert_single_grant_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cpu_req_accept));

  assert_inst_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid == 2'b11 && |cpu_req_accept) |-> (cpu_req_accept == 2'b01));

  assert_retry_follows_reply_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_retry != '0) |-> $past(mem_rsp_valid));

  assert_mem_refused_parks_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_accept) |=> !mem_req_valid);

  assert_no_overflow_mem_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_load && mem_occ));

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assert_retry_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      cpu_retry[i] |=> !cpu_retry[i]);

    assert_rsp_refused_parks_R10: assert property (@(posedge clk) disable iff (rst)
      (cpu_rsp_valid[i] && !cpu_rsp_accept[i]) |=> !cpu_rsp_valid[i]);

    assert_no_overflow_rsp_R11: assert property (@(posedge clk) disable iff (rst)
      !(rsp_load[i] && rsp_occ[i]));
  end
endmodule

bind fwd_two_port fwd_two_port_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .cpu_req_valid  (cpu_req_valid),
  .cpu_req_accept (cpu_req_accept),
  .cpu_retry      (cpu_retry),
  .cpu_rsp_valid  (cpu_rsp_valid),
  .cpu_rsp_accept (cpu_rsp_accept),
  .mem_req_valid  (mem_req_valid),
  .mem_req_accept (mem_req_accept),
  .mem_rsp_valid  (mem_rsp_valid),
  .mem_load       (mem_load),
  .mem_occ        (mem_occ),
  .rsp_load       (rsp_load),
  .rsp_occ        (rsp_occ)
);

// File: tb/sim_fwd_two_port.sv
module sim_fwd_two_port;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]         cpu_req_valid;
  logic [1:0][AW-1:0] cpu_req_addr;
  logic [1:0]         cpu_req_we;
  logic [1:0][DW-1:0] cpu_req_wdata;
  logic [1:0]         cpu_req_fetch;
  logic [1:0]         cpu_req_accept;
  logic [1:0]         cpu_retry;
  logic [1:0]         cpu_rsp_valid;
  logic [1:0][DW-1:0] cpu_rsp_data;
  logic [1:0]         cpu_rsp_accept;
  logic [1:0]         cpu_rsp_retry;
  logic               mem_req_valid;
  logic [AW-1:0]      mem_req_addr;
  logic               mem_req_we;
  logic [DW-1:0]      mem_req_wdata;
  logic               mem_req_fetch;
  logic               mem_req_accept;
  logic               mem_req_retry;
  logic               mem_rsp_valid;
  logic [DW-1:0]      mem_rsp_data;

  fwd_two_port #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic          port;
    logic [AW-1:0] addr;
    logic          we;
    logic [DW-1:0] wdata;
    logic          fetch;
    logic [DW-1:0] rdata;
    logic [3:0]    lat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'h0100, 1'b0, 32'h0,         1'b1, 32'hA0A0_0001, 4'd1},
    '{1'b1, 16'h2004, 1'b1, 32'hDEAD_BEEF, 1'b0, 32'h0000_0000, 4'd2},
    '{1'b1, 16'h3008, 1'b0, 32'h0,         1'b0, 32'h1234_5678, 4'd4},
    '{1'b0, 16'h0104, 1'b0, 32'h0,         1'b1, 32'hCAFE_0002, 4'd3},
    '{1'b1, 16'h400C, 1'b0, 32'h0,         1'b1, 32'h5555_AAAA, 4'd2},
    '{1'b0, 16'h0F00, 1'b1, 32'h0BAD_F00D, 1'b0, 32'h0000_0000, 4'd1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic drive(input int p, input logic [AW-1:0] a, input logic w,
                       input logic [DW-1:0] d, input logic f);
    cpu_req_valid[p] = 1'b1;
    cpu_req_addr[p]  = a;
    cpu_req_we[p]    = w;
    cpu_req_wdata[p] = d;
    cpu_req_fetch[p] = f;
  endtask

  // One full transaction; optional probe on the other port while busy.
  task automatic do_txn(input int p, input logic [AW-1:0] a, input logic w,
                        input logic [DW-1:0] d, input logic f,
                        input logic [DW-1:0] rd, input int lat,
                        input bit probe, input bit exp_ret);
    int o = 1 - p;
    int dst = f ? 0 : 1;
    drive(p, a, w, d, f);
    #1 chk("R2 accept", 64'(cpu_req_accept), 64'(2'b01 << p));
    tick();
    cpu_req_valid[p] = 1'b0;
    chk("R2 mem valid", 64'(mem_req_valid), 64'd1);
    chk("R2 fields", 64'({mem_req_addr, mem_req_we, mem_req_wdata, mem_req_fetch}),
        64'({a, w, d, f}));
    if (probe) begin
      drive(o, 16'hFFF0, 1'b0, 32'h0, 1'b0);
      #1 chk("R3 refuse while busy", 64'(cpu_req_accept), 64'd0);
    end
    tick();
    cpu_req_valid[o] = 1'b0;
    chk("R2 mem taken", 64'(mem_req_valid), 64'd0);
    for (int k = 2; k <= lat; k++) tick();
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = rd;
    tick();
    mem_rsp_valid = 1'b0;
    chk("R4 route", 64'(cpu_rsp_valid), 64'(2'b01 << dst));
    chk("R4 data", 64'(cpu_rsp_data[dst]), 64'(rd));
    chk("R7 R8 retry pulse", 64'(cpu_retry[o]), 64'(exp_ret));
    tick();
    chk("R4 reply taken", 64'(cpu_rsp_valid), 64'd0);
    chk("R7 single pulse", 64'(cpu_retry), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    cpu_req_valid  = '0;
    cpu_req_addr   = '0;
    cpu_req_we     = '0;
    cpu_req_wdata  = '0;
    cpu_req_fetch  = '0;
    cpu_rsp_accept = 2'b11;
    cpu_rsp_retry  = '0;
    mem_req_accept = 1'b1;
    mem_req_retry  = 1'b0;
    mem_rsp_valid  = 1'b0;
    mem_rsp_data   = '0;
    repeat (3) tick();
    chk("R1 mem idle in reset", 64'(mem_req_valid), 64'd0);
    chk("R1 rsp idle in reset", 64'(cpu_rsp_valid), 64'd0);
    chk("R1 no retry in reset", 64'(cpu_retry), 64'd0);
    rst = 1'b0;
    tick();
    chk("R1 quiet after reset", 64'({mem_req_valid, cpu_rsp_valid, cpu_retry}), 64'd0);

    // Table walk: one transaction per vector, the other port probed while busy.
    foreach (VECS[i]) begin
      do_txn(int'(VECS[i].port), VECS[i].addr, VECS[i].we, VECS[i].wdata,
             VECS[i].fetch, VECS[i].rdata, int'(VECS[i].lat), 1'b1, 1'b1);
    end

    // R6: both ports in one free cycle.
    drive(0, 16'h0AA0, 1'b0, 32'h0, 1'b1);
    drive(1, 16'h0BB0, 1'b1, 32'h7777_0000, 1'b0);
    #1 chk("R6 inst wins", 64'(cpu_req_accept), 64'b01);
    tick();
    cpu_req_valid = '0;
    chk("R6 inst fields", 64'(mem_req_addr), 64'h0AA0);
    tick();
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'h0000_0A0A;
    tick();
    mem_rsp_valid = 1'b0;
    chk("R6 data owes retry", 64'(cpu_retry), 64'b10);
    tick();

    // R5: request in the reply cycle is accepted.
    drive(0, 16'h0120, 1'b0, 32'h0, 1'b1);
    tick();
    cpu_req_valid[0] = 1'b0;
    tick();
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'h1111_2222;
    drive(1, 16'h5550, 1'b1, 32'h3333_4444, 1'b0);
    #1 chk("R5 accept in reply cycle", 64'(cpu_req_accept), 64'b10);
    tick();
    mem_rsp_valid = 1'b0;
    cpu_req_valid[1] = 1'b0;
    chk("R5 first reply", 64'(cpu_rsp_valid), 64'b01);
    chk("R5 second forwarded", 64'({mem_req_valid, mem_req_addr}), 64'({1'b1, 16'h5550}));
    tick();
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'h0;
    tick();
    mem_rsp_valid = 1'b0;
    chk("R5 second reply", 64'(cpu_rsp_valid), 64'b10);
    tick();

    // R9: memory refuses twice, retries re-offer the same request.
    drive(1, 16'h6660, 1'b1, 32'h8888_9999, 1'b0);
    tick();
    cpu_req_valid[1] = 1'b0;
    mem_req_accept = 1'b0;
    chk("R9 first offer", 64'(mem_req_valid), 64'd1);
    tick();
    chk("R9 parked", 64'(mem_req_valid), 64'd0);
    tick();
    chk("R9 stays parked", 64'(mem_req_valid), 64'd0);
    mem_req_retry = 1'b1;
    tick();
    mem_req_retry = 1'b0;
    chk("R9 reoffer", 64'({mem_req_valid, mem_req_addr, mem_req_wdata}),
        64'({1'b1, 16'h6660, 32'h8888_9999}));
    tick();
    chk("R9 parked again", 64'(mem_req_valid), 64'd0);
    mem_req_retry = 1'b1;
    tick();
    mem_req_retry  = 1'b0;
    mem_req_accept = 1'b1;
    chk("R9 third offer", 64'({mem_req_valid, mem_req_addr}), 64'({1'b1, 16'h6660}));
    tick();
    chk("R9 taken", 64'(mem_req_valid), 64'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'h0;
    tick();
    mem_rsp_valid = 1'b0;
    chk("R9 reply", 64'(cpu_rsp_valid), 64'b10);
    tick();

    // R10 and R8: data reply refused and parked; owed retry withheld meanwhile.
    drive(1, 16'h7770, 1'b0, 32'h0, 1'b0);
    tick();
    cpu_req_valid[1]  = 1'b0;
    cpu_rsp_accept[1] = 1'b0;
    tick();
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'hABCD_0001;
    tick();
    mem_rsp_valid = 1'b0;
    chk("R10 first offer", 64'(cpu_rsp_valid), 64'b10);
    tick();
    chk("R10 parked", 64'(cpu_rsp_valid), 64'd0);
    cpu_rsp_accept[1] = 1'b1;
    drive(0, 16'h0200, 1'b0, 32'h0, 1'b1);
    #1 chk("R8 inst accepted", 64'(cpu_req_accept), 64'b01);
    tick();
    cpu_req_valid[0] = 1'b0;
    drive(1, 16'h7774, 1'b0, 32'h0, 1'b0);
    #1 chk("R3 data refused", 64'(cpu_req_accept), 64'd0);
    tick();
    cpu_req_valid[1] = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'hABCD_0002;
    tick();
    mem_rsp_valid = 1'b0;
    chk("R8 inst reply", 64'({cpu_rsp_valid, cpu_rsp_data[0]}), 64'({2'b01, 32'hABCD_0002}));
    chk("R8 retry withheld", 64'(cpu_retry), 64'd0);
    cpu_rsp_retry[1] = 1'b1;
    tick();
    cpu_rsp_retry[1] = 1'b0;
    chk("R10 reoffer", 64'({cpu_rsp_valid, cpu_rsp_data[1]}), 64'({2'b10, 32'hABCD_0001}));
    tick();
    chk("R10 taken", 64'(cpu_rsp_valid), 64'd0);
    // Debt paid after the next reply now that the slot is empty (R8).
    do_txn(0, 16'h0300, 1'b0, 32'h0, 1'b1, 32'h0BEE_F000, 2, 1'b0, 1'b1);

    summary();
    $finish;
  end
endmodule